// File: doc/BRIEF.md
# Remote DMA Data Port Engine

This block lets a host reach a local packet RAM through one data port instead of a full address bus. The host first loads a 16-bit remote address and a 16-bit remote byte count, one byte per register write. It then issues a read or write command and moves data through the port. Each port access transfers either one byte or one little-endian 16-bit word, chosen by a configuration bit. The address steps forward after every access. When it reaches the end of a receive ring, it jumps back to the ring's first page, so a host can drain a frame that wraps around the ring in one pass.

The count tracks how many bytes are left. When the count runs out, the engine sets a completion bit in its interrupt status register. That bit, masked by an interrupt mask register, drives a level interrupt line. A command issued with an empty count completes at once. The local RAM sits outside the block: the engine drives an enable, a write enable, a byte address, byte enables and write data, and takes the read data back combinationally. Accesses outside the packet-memory window never reach the RAM.

Top module: `rdma_port_engine`

## Requirements
- R1: After synchronous reset the address and count read 0, the interrupt status reads 0x80 (bit 7 is the reset-done flag), the mask is 0 and the interrupt is low.
- R2: Register selects 1 and 2 load the low and high byte of the address, and selects 3 and 4 load the low and high byte of the count. Each write replaces only its own byte.
- R3: With configuration bit 0 clear (byte mode), a port access with a nonzero count moves one byte at the current address. Write data is taken from port bits 7:0, and read data comes back as 0x00 followed by the byte. The address then advances by 1.
- R4: With configuration bit 0 set (word mode), a port access moves two bytes at the address with bit 0 forced to 0. The low byte is at the even address, and byte enables are 2'b11. The address register itself advances by 2 without being realigned.
- R5: If the advanced address equals {ring last page, 8'h00}, it is replaced by {ring first page, 8'h00}. Select 5 writes the first page and select 6 writes the last page.
- R6: An access with count less than or equal to the access size sets the count to 0 and sets status bit 6. Otherwise the count drops by the access size.
- R7: A command write (select 0) with bit 3 (read) or bit 4 (write) set while the count is 0 sets status bit 6 in the next cycle. With the count nonzero, or with neither bit set, status bit 6 is left alone.
- R8: An access whose effective address lies outside [WIN_BASE, WIN_LIMIT) keeps mem_en low, and a read returns 16'hFFFF. The address and count still advance.
- R9: A port access while the count is 0 leaves the address and count unchanged and keeps mem_en low, and a read returns 16'hFFFF.
- R10: Writing select 8 clears each status bit among 6:0 whose data bit is 1, and bit 7 is unaffected. Any command write clears bit 7. A set and a clear of the same bit in one cycle leave it set.
- R11: irq is high exactly when some bit among 6:0 is set in both the status and the mask (select 9). Bit 7 never raises irq.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 4 | Register select |
| reg_wdata | input | 8 | Register write data |
| port_rd | input | 1 | Data port read strobe |
| port_wr | input | 1 | Data port write strobe |
| port_wdata | input | 16 | Data port write data |
| port_rdata | output | 16 | Data port read data |
| mem_en | output | 1 | Local RAM access enable |
| mem_we | output | 1 | Local RAM write enable |
| mem_addr | output | 16 | Local RAM byte address |
| mem_be | output | 2 | Local RAM byte enables |
| mem_wdata | output | 16 | Local RAM write data |
| mem_rdata | input | 16 | Local RAM read data (low byte at mem_addr) |
| cur_addr | output | 16 | Current remote address |
| cur_count | output | 16 | Remaining remote byte count |
| irq_status | output | 8 | Interrupt status |
| irq | output | 1 | Interrupt request |

## Verification
The bench starts a word-mode transfer at an odd address and checks the effective address and the advance independently. A design that realigned the register would lose a byte, and one that did not force the memory address would write a split word. It steps the address across the ring's last page in both byte and word mode to catch wrap compares made before the increment or with the wrong page. It also runs an odd count in word mode, which must end at 0 rather than underflow. Finally it sends empty-count commands and port accesses, and out-of-window accesses, where a faulty design would move the pointer, touch RAM or miss the immediate completion.

// File: rtl/rdma_pkg.sv
package rdma_pkg;
    localparam int ADDR_W  = 16;
    localparam int PAGE_W  = 8;
    localparam int OFS_W   = ADDR_W - PAGE_W;
    localparam int BYTE_W  = 8;
    localparam int DATA_W  = 16;
    localparam int LANES   = DATA_W / BYTE_W;
    localparam int HALVES  = ADDR_W / BYTE_W;
    localparam int SEL_W   = 4;
    localparam int DONE_BIT  = 6;
    localparam int RESET_BIT = 7;
    localparam int CMD_RD_BIT = 3;
    localparam int CMD_WR_BIT = 4;
    localparam int WORD_CFG_BIT = 0;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [PAGE_W-1:0] page_t;
    typedef logic [BYTE_W-1:0] byte_t;
    typedef logic [DATA_W-1:0] data_t;

    typedef enum logic [SEL_W-1:0] {
        SEL_CMD        = 4'd0,
        SEL_ADDR_LO    = 4'd1,
        SEL_ADDR_HI    = 4'd2,
        SEL_CNT_LO     = 4'd3,
        SEL_CNT_HI     = 4'd4,
        SEL_RING_FIRST = 4'd5,
        SEL_RING_LAST  = 4'd6,
        SEL_CFG        = 4'd7,
        SEL_STATUS     = 4'd8,
        SEL_MASK       = 4'd9
    } reg_sel_e;

    typedef struct packed {
        addr_t addr;
        addr_t count;
        logic  finished;
    } step_t;

    function automatic addr_t access_size(input logic word);
        return word ? ADDR_W'(2) : ADDR_W'(1);
    endfunction

    function automatic step_t advance(input addr_t a, input addr_t c, input logic word,
                                      input page_t first_pg, input page_t last_pg);
        step_t r;
        addr_t sz;
        sz = access_size(word);
        r.addr = a + sz;
        if (r.addr == {last_pg, {OFS_W{1'b0}}})
            r.addr = {first_pg, {OFS_W{1'b0}}};
        if (c <= sz) begin
            r.count    = '0;
            r.finished = 1'b1;
        end else begin
            r.count    = c - sz;
            r.finished = 1'b0;
        end
        return r;
    endfunction
endpackage

// File: rtl/rdma_cfg.sv
module rdma_cfg
    import rdma_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             reg_wr,
    input  logic [SEL_W-1:0] reg_sel,
    input  byte_t            reg_wdata,
    output logic [HALVES-1:0] ld_addr,
    output logic [HALVES-1:0] ld_cnt,
    output logic             cmd_wr,
    output logic             stat_wr,
    output page_t            ring_first,
    output page_t            ring_last,
    output logic             word_mode,
    output byte_t            irq_mask
);
    reg_sel_e sel;
    assign sel = reg_sel_e'(reg_sel);

    always_comb begin
        ld_addr = '0;
        ld_cnt  = '0;
        cmd_wr  = 1'b0;
        stat_wr = 1'b0;
        if (reg_wr) begin
            case (sel)
                SEL_CMD:     cmd_wr     = 1'b1;
                SEL_ADDR_LO: ld_addr[0] = 1'b1;
                SEL_ADDR_HI: ld_addr[1] = 1'b1;
                SEL_CNT_LO:  ld_cnt[0]  = 1'b1;
                SEL_CNT_HI:  ld_cnt[1]  = 1'b1;
                SEL_STATUS:  stat_wr    = 1'b1;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ring_first <= '0;
            ring_last  <= '0;
            word_mode  <= 1'b0;
            irq_mask   <= '0;
        end else if (reg_wr) begin
            case (sel)
                SEL_RING_FIRST: ring_first <= reg_wdata;
                SEL_RING_LAST:  ring_last  <= reg_wdata;
                SEL_CFG:        word_mode  <= reg_wdata[WORD_CFG_BIT];
                SEL_MASK:       irq_mask   <= reg_wdata;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/rdma_ptr.sv
module rdma_ptr
    import rdma_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [HALVES-1:0] ld_addr,
    input  logic [HALVES-1:0] ld_cnt,
    input  byte_t             wdata,
    input  logic              step,
    input  logic              word_mode,
    input  page_t             ring_first,
    input  page_t             ring_last,
    output addr_t             addr,
    output addr_t             count,
    output logic              finished
);
    addr_t addr_q, count_q;
    step_t nxt;

    always_comb nxt = advance(addr_q, count_q, word_mode, ring_first, ring_last);

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q  <= '0;
            count_q <= '0;
        end else begin
            if (step) begin
                addr_q  <= nxt.addr;
                count_q <= nxt.count;
            end
            for (int h = 0; h < HALVES; h++) begin
                if (ld_addr[h]) addr_q[h*BYTE_W +: BYTE_W]  <= wdata;
                if (ld_cnt[h])  count_q[h*BYTE_W +: BYTE_W] <= wdata;
            end
        end
    end

    assign addr     = addr_q;
    assign count    = count_q;
    assign finished = step && nxt.finished;
endmodule

// File: rtl/rdma_mem_if.sv
module rdma_mem_if
    import rdma_pkg::*;
#(
    parameter addr_t WIN_BASE  = 16'h4000,
    parameter addr_t WIN_LIMIT = 16'h8000
) (
    input  addr_t             addr,
    input  logic              word_mode,
    input  logic              access,
    input  logic              is_write,
    input  data_t             port_wdata,
    input  data_t             mem_rdata,
    output logic              mem_en,
    output logic              mem_we,
    output addr_t             mem_addr,
    output logic [LANES-1:0]  mem_be,
    output data_t             mem_wdata,
    output data_t             port_rdata
);
    addr_t eff;
    logic  in_win;

    assign eff    = word_mode ? {addr[ADDR_W-1:1], 1'b0} : addr;
    assign in_win = (eff >= WIN_BASE) && (eff < WIN_LIMIT);

    assign mem_en   = access && in_win;
    assign mem_we   = mem_en && is_write;
    assign mem_addr = eff;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        if (l == 0) begin : g_low
            assign mem_be[l] = 1'b1;
            assign mem_wdata[l*BYTE_W +: BYTE_W] = port_wdata[l*BYTE_W +: BYTE_W];
        end else begin : g_high
            assign mem_be[l] = word_mode;
            assign mem_wdata[l*BYTE_W +: BYTE_W] =
                word_mode ? port_wdata[l*BYTE_W +: BYTE_W] : '0;
        end
    end

    always_comb begin
        if (mem_en && !is_write)
            port_rdata = word_mode ? mem_rdata : {{(DATA_W-BYTE_W){1'b0}}, mem_rdata[BYTE_W-1:0]};
        else
            port_rdata = '1;
    end
endmodule

// File: rtl/rdma_irq.sv
module rdma_irq
    import rdma_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  cmd_wr,
    input  logic  stat_wr,
    input  byte_t wdata,
    input  logic  set_done,
    input  byte_t irq_mask,
    output byte_t status,
    output logic  irq
);
    byte_t clr, set;

    always_comb begin
        clr = '0;
        set = '0;
        if (stat_wr) clr[RESET_BIT-1:0] = wdata[RESET_BIT-1:0];
        if (cmd_wr)  clr[RESET_BIT] = 1'b1;
        set[DONE_BIT] = set_done;
    end

    always_ff @(posedge clk) begin
        if (rst) status <= byte_t'(1) << RESET_BIT;
        else     status <= (status & ~clr) | set;
    end

    assign irq = |(status[RESET_BIT-1:0] & irq_mask[RESET_BIT-1:0]);
endmodule

// File: rtl/rdma_port_engine.sv
module rdma_port_engine
    import rdma_pkg::*;
#(
    parameter logic [15:0] WIN_BASE  = 16'h4000,
    parameter logic [15:0] WIN_LIMIT = 16'h8000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_wr,
    input  logic [3:0]  reg_sel,
    input  logic [7:0]  reg_wdata,
    input  logic        port_rd,
    input  logic        port_wr,
    input  logic [15:0] port_wdata,
    output logic [15:0] port_rdata,
    output logic        mem_en,
    output logic        mem_we,
    output logic [15:0] mem_addr,
    output logic [1:0]  mem_be,
    output logic [15:0] mem_wdata,
    input  logic [15:0] mem_rdata,
    output logic [15:0] cur_addr,
    output logic [15:0] cur_count,
    output logic [7:0]  irq_status,
    output logic        irq
);
    logic [HALVES-1:0] ld_addr, ld_cnt;
    logic  cmd_wr, stat_wr, word_mode, finished, access, zero_len;
    page_t ring_first, ring_last;
    byte_t irq_mask;

    rdma_cfg u_cfg (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
        .ld_addr(ld_addr), .ld_cnt(ld_cnt), .cmd_wr(cmd_wr), .stat_wr(stat_wr),
        .ring_first(ring_first), .ring_last(ring_last), .word_mode(word_mode),
        .irq_mask(irq_mask)
    );

    assign access   = (port_rd || port_wr) && (cur_count != '0);
    assign zero_len = cmd_wr && (reg_wdata[CMD_RD_BIT] || reg_wdata[CMD_WR_BIT])
                      && (cur_count == '0);

    rdma_ptr u_ptr (
        .clk(clk), .rst(rst), .ld_addr(ld_addr), .ld_cnt(ld_cnt), .wdata(reg_wdata),
        .step(access), .word_mode(word_mode), .ring_first(ring_first),
        .ring_last(ring_last), .addr(cur_addr), .count(cur_count), .finished(finished)
    );

    rdma_mem_if #(.WIN_BASE(WIN_BASE), .WIN_LIMIT(WIN_LIMIT)) u_mem (
        .addr(cur_addr), .word_mode(word_mode), .access(access), .is_write(port_wr),
        .port_wdata(port_wdata), .mem_rdata(mem_rdata), .mem_en(mem_en), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_be(mem_be), .mem_wdata(mem_wdata), .port_rdata(port_rdata)
    );

    rdma_irq u_irq (
        .clk(clk), .rst(rst), .cmd_wr(cmd_wr), .stat_wr(stat_wr), .wdata(reg_wdata),
        .set_done(finished || zero_len), .irq_mask(irq_mask), .status(irq_status), .irq(irq)
    );
endmodule

// File: rtl/rdma_port_engine_chk.sv
module rdma_port_engine_chk #(
    parameter logic [15:0] WIN_BASE  = 16'h4000,
    parameter logic [15:0] WIN_LIMIT = 16'h8000
) (
    input logic        clk,
    input logic        rst,
    input logic        reg_wr,
    input logic [3:0]  reg_sel,
    input logic [7:0]  reg_wdata,
    input logic        port_rd,
    input logic        port_wr,
    input logic        mem_en,
    input logic [15:0] mem_addr,
    input logic [15:0] cur_addr,
    input logic [15:0] cur_count,
    input logic [7:0]  irq_status,
    input logic        irq,
    input logic        word_mode,
    input logic [7:0]  irq_mask
);
    logic [15:0] sz;
    logic        acc_req;
    assign sz      = word_mode ? 16'd2 : 16'd1;
    assign acc_req = (port_rd || port_wr) && !reg_wr;

    // R9
    a_r9_idle_hold: assert property (@(posedge clk) disable iff (rst)
        (acc_req && cur_count == 16'd0) |=> ($stable(cur_addr) && cur_count == 16'd0));
    // R9
    a_r9_no_mem: assert property (@(posedge clk) disable iff (rst)
        (cur_count == 16'd0) |-> !mem_en);
    // R8
    a_r8_window: assert property (@(posedge clk) disable iff (rst)
        mem_en |-> (mem_addr >= WIN_BASE && mem_addr < WIN_LIMIT));
    // R4
    a_r4_even_word: assert property (@(posedge clk) disable iff (rst)
        (mem_en && word_mode) |-> !mem_addr[0]);
    // R6
    a_r6_finish: assert property (@(posedge clk) disable iff (rst)
        (acc_req && cur_count != 16'd0 && cur_count <= sz) |=> (cur_count == 16'd0 && irq_status[6]));
    // R6
    a_r6_decrement: assert property (@(posedge clk) disable iff (rst)
        (acc_req && cur_count > sz) |=> (cur_count == $past(cur_count) - $past(sz)));
    // R7
    a_r7_zero_len: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_sel == 4'd0 && (reg_wdata[3] || reg_wdata[4]) && cur_count == 16'd0)
        |=> irq_status[6]);
    // R11
    a_r11_masked_off: assert property (@(posedge clk) disable iff (rst)
        (irq_mask[6:0] == 7'd0) |-> !irq);
endmodule

bind rdma_port_engine rdma_port_engine_chk #(.WIN_BASE(WIN_BASE), .WIN_LIMIT(WIN_LIMIT)) u_chk (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .port_rd(port_rd), .port_wr(port_wr), .mem_en(mem_en), .mem_addr(mem_addr),
    .cur_addr(cur_addr), .cur_count(cur_count), .irq_status(irq_status), .irq(irq),
    .word_mode(word_mode), .irq_mask(irq_mask)
);

// File: tb/rdma_port_engine_tb.sv
module rdma_port_engine_tb;
    localparam int WB = 16'h4000;
    localparam int WL = 16'h8000;
    localparam int WSIZE = WL - WB;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_sel = '0;
    logic [7:0]  reg_wdata = '0;
    logic        port_rd = 1'b0, port_wr = 1'b0;
    logic [15:0] port_wdata = '0;
    logic [15:0] port_rdata, mem_addr, mem_wdata, mem_rdata, cur_addr, cur_count;
    logic        mem_en, mem_we, irq;
    logic [1:0]  mem_be;
    logic [7:0]  irq_status;

    int vectors = 0, fails = 0, cyc = 0;
    bit done = 0;

    always #10 clk = ~clk;

    rdma_port_engine u_dut (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
        .port_rd(port_rd), .port_wr(port_wr), .port_wdata(port_wdata), .port_rdata(port_rdata),
        .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .cur_addr(cur_addr),
        .cur_count(cur_count), .irq_status(irq_status), .irq(irq)
    );

    // Local RAM covering the window
    logic [7:0] ram [WSIZE];
    initial for (int i = 0; i < WSIZE; i++) ram[i] = 8'(i * 7 + 3);

    function automatic logic [7:0] ram_at(input int a);
        if (a >= WB && a < WL) return ram[a - WB];
        return 8'h00;
    endfunction

    assign mem_rdata = {ram_at(int'(mem_addr) + 1), ram_at(int'(mem_addr))};

    always @(posedge clk) begin
        if (mem_en && mem_we && mem_addr >= WB && mem_addr < WL) begin
            ram[mem_addr - WB] <= mem_wdata[7:0];
            if (mem_be[1] && mem_addr + 1 < WL) ram[mem_addr + 1 - WB] <= mem_wdata[15:8];
        end
    end

    // Behavioural reference state
    int m_addr = 0, m_cnt = 0, m_first = 0, m_last = 0, m_mask = 0, m_stat = 8'h80;
    bit m_word = 0;

    always @(posedge clk) begin
        int clr, set, sz, na;
        if (rst) begin
            m_addr = 0; m_cnt = 0; m_first = 0; m_last = 0; m_mask = 0;
            m_stat = 8'h80; m_word = 0;
        end else begin
            clr = 0; set = 0;
            sz = m_word ? 2 : 1;
            if ((port_rd || port_wr) && m_cnt != 0) begin
                na = (m_addr + sz) & 16'hFFFF;
                if (na == (m_last << 8)) na = m_first << 8;
                m_addr = na;
                if (m_cnt <= sz) begin m_cnt = 0; set = 8'h40; end
                else m_cnt = m_cnt - sz;
            end
            if (reg_wr) begin
                case (reg_sel)
                    4'd0: begin
                        if ((reg_wdata[3] || reg_wdata[4]) && m_cnt == 0 && !(port_rd || port_wr))
                            set = 8'h40;
                        clr = clr | 8'h80;
                    end
                    4'd1: m_addr = (m_addr & 16'hFF00) | int'(reg_wdata);
                    4'd2: m_addr = (m_addr & 16'h00FF) | (int'(reg_wdata) << 8);
                    4'd3: m_cnt  = (m_cnt & 16'hFF00) | int'(reg_wdata);
                    4'd4: m_cnt  = (m_cnt & 16'h00FF) | (int'(reg_wdata) << 8);
                    4'd5: m_first = int'(reg_wdata);
                    4'd6: m_last  = int'(reg_wdata);
                    4'd7: m_word  = reg_wdata[0];
                    4'd8: clr = clr | (int'(reg_wdata) & 8'h7F);
                    4'd9: m_mask = int'(reg_wdata);
                    default: ;
                endcase
            end
            m_stat = ((m_stat & ~clr) | set) & 8'hFF;
        end
    end

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h (t=%0t)", tag, act, exp, $time);
        end
    endtask

    // Compare every cycle, 5 ns before the rising edge
    always begin
        int ea, sz;
        bit acc, inwin;
        logic [15:0] exp_rd;
        @(negedge clk);
        #5;
        if (!done) begin
            vectors++;
            sz = m_word ? 2 : 1;
            acc = (port_rd || port_wr) && m_cnt != 0;
            ea = m_word ? (m_addr & 16'hFFFE) : m_addr;
            inwin = ea >= WB && ea < WL;
            chk("R1 R2 R3 R4 R5 R9 address", cur_addr, 16'(m_addr));
            chk("R1 R2 R6 R9 count", cur_count, 16'(m_cnt));
            chk("R1 R6 R7 R10 status", {8'h00, irq_status}, 16'(m_stat));
            chk("R11 irq", {15'd0, irq}, {15'd0, ((m_stat & m_mask & 8'h7F) != 0)});
            chk("R3 R4 R8 R9 mem_en", {15'd0, mem_en}, {15'd0, acc && inwin});
            chk("R3 R8 R9 mem_we", {15'd0, mem_we}, {15'd0, acc && inwin && port_wr});
            if (acc && inwin) begin
                chk("R3 R4 mem_addr", mem_addr, 16'(ea));
                chk("R3 R4 mem_be", {14'd0, mem_be}, m_word ? 16'd3 : 16'd1);
                if (port_wr)
                    chk("R3 R4 mem_wdata", mem_wdata,
                        m_word ? port_wdata : {8'h00, port_wdata[7:0]});
            end
            if (port_rd && !port_wr && acc && inwin)
                exp_rd = m_word ? {ram_at(ea + 1), ram_at(ea)} : {8'h00, ram_at(ea)};
            else
                exp_rd = 16'hFFFF;
            chk("R3 R4 R8 R9 port_rdata", port_rdata, exp_rd);
        end
    end

    task automatic wreg(input logic [3:0] sel, input logic [7:0] val);
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = sel; reg_wdata = val;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic pwrite(input logic [15:0] d);
        @(negedge clk);
        port_wr = 1'b1; port_wdata = d;
        @(negedge clk);
        port_wr = 1'b0;
    endtask

    task automatic pread();
        @(negedge clk);
        port_rd = 1'b1;
        @(negedge clk);
        port_rd = 1'b0;
    endtask

    task automatic setup(input logic [15:0] a, input logic [15:0] c);
        wreg(4'd1, a[7:0]); wreg(4'd2, a[15:8]);
        wreg(4'd3, c[7:0]); wreg(4'd4, c[15:8]);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc >= 50000 && !done) begin
            done = 1;
            fails++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        repeat (2) @(negedge clk);              // R1 reset state compared each cycle
        wreg(4'd9, 8'h80);                       // R11: bit 7 set and masked, irq stays low
        wreg(4'd8, 8'h80);                       // R10: bit 7 not cleared by W1C
        wreg(4'd5, 8'h40); wreg(4'd6, 8'h60);    // R5 ring pages
        // R2 half loading
        wreg(4'd1, 8'h10); wreg(4'd2, 8'h41); wreg(4'd2, 8'h40);
        wreg(4'd3, 8'h02); wreg(4'd4, 8'h01); wreg(4'd4, 8'h00); wreg(4'd3, 8'h03);
        wreg(4'd0, 8'h10);                       // R10 command clears bit 7
        // R3 byte writes, R6 completion
        pwrite(16'h11AA); pwrite(16'h22BB); pwrite(16'h33CC);
        pwrite(16'h44DD);                        // R9 ignored at count 0
        pread();                                 // R9 read returns ones
        wreg(4'd9, 8'h40);                       // R11 irq rises
        wreg(4'd8, 8'h40);                       // R10 clear
        // R3 byte reads
        setup(16'h4010, 16'd3);
        wreg(4'd0, 8'h08);
        pread(); pread(); pread();
        // R4 word mode from odd address, odd count
        wreg(4'd7, 8'h01);
        setup(16'h4011, 16'd5);
        pwrite(16'h1234); pwrite(16'h5678); pwrite(16'h9ABC);
        setup(16'h4010, 16'd6);
        pread(); pread(); pread();
        // R5 wrap in byte and word mode
        wreg(4'd7, 8'h00);
        setup(16'h5FFE, 16'd4);
        pwrite(16'h0001); pwrite(16'h0002); pwrite(16'h0003); pwrite(16'h0004);
        wreg(4'd7, 8'h01);
        setup(16'h5FFC, 16'd6);
        pread(); pread(); pwrite(16'hBEEF);
        // R7 zero-length command
        wreg(4'd8, 8'h7F);
        wreg(4'd0, 8'h00);                       // neither bit: no completion
        wreg(4'd0, 8'h08);                       // read command at count 0
        wreg(4'd8, 8'h40);
        wreg(4'd0, 8'h10);                       // write command at count 0
        wreg(4'd8, 8'h40);
        setup(16'h4000, 16'd2);
        wreg(4'd0, 8'h08);                       // nonzero count: no completion
        // R8 out of window
        wreg(4'd7, 8'h00);
        setup(16'h2000, 16'd3);
        pwrite(16'h0055); pread();
        setup(16'h7FFF, 16'd2);
        pread(); pwrite(16'h0066);
        // R11 masked bits
        wreg(4'd9, 8'h00);
        wreg(4'd0, 8'h08);
        repeat (3) @(negedge clk);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule